// File: doc/BRIEF.md
# Decimal Digit Store and Register Block Transfer Sequencer

This block is a multi-cycle sequencer that moves bytes between a 16-entry register file and a 4096-byte single-port memory, with the memory address taken from a 16-bit index value. It runs one of three operations per start pulse. The digit store converts one register's 8-bit value into three decimal digits and writes them to memory, hundreds digit first. The block store copies registers 0 through X to consecutive bytes. The block load fills registers 0 through X from consecutive bytes.

The surrounding core does the decoding. It supplies the operation code, the register selector X and the index value, then waits for `done`. The index value is only read, never written back. Memory writes below address 512 are refused. A refused write stops the operation without a `done` pulse and raises a fault flag that stays high until reset.

The controller has six states. IDLE waits for a start pulse; a valid code takes it to DIGITS, STORE or LOAD, and the reserved code leaves it in IDLE. DIGITS steps through its three writes and then goes to FINISH. STORE steps once per register up to X and then goes to FINISH. From either write state, a refused write takes the controller straight back to IDLE. LOAD issues one read per register up to X, passes through LOAD_TAIL to retire the final read, and then goes to FINISH. FINISH returns to IDLE after one cycle.

Top module: `bcd_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_we`, `mem_re` and `rf_we` are all 0. No memory or register access happens while the block is idle.
- R2: Operation code 2'b00 (digit store) writes three bytes: the hundreds digit of register X at address I, the tens digit at I+1 and the ones digit at I+2. Each byte holds a value from 0 to 9.
- R3: Operation code 2'b01 (block store) writes register n to address I+n for every n from 0 to X inclusive. It never reads memory and writes no other address.
- R4: Operation code 2'b10 (block load) reads address I+n into register n for every n from 0 to X inclusive. Registers above X keep their values.
- R5: I is the low 12 bits of `idx`, and the upper 4 bits are ignored. Address I+n wraps modulo 4096, and consecutive writes of one operation go to consecutive addresses.
- R6: A write whose address is below 512 never reaches the memory, so `mem_we` is never high with `mem_addr` below 512.
- R7: A refused write ends the operation at once without a `done` pulse and sets `fault`. `fault` stays high until reset, and later operations still run.
- R8: `done` is high for exactly one cycle. With start sampled at edge 0, `done` is high in cycle 4 for the digit store, in cycle X+2 for the block store and in cycle X+3 for the block load. One byte moves per cycle, and read data arrives one cycle after its read.
- R9: `start` is ignored while `busy` is high, and code 2'b11 starts nothing. `op`, `xsel`, `idx` and the digit-store source value are captured at start, so later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Operation code: 00 digits, 01 store, 10 load, 11 none |
| xsel | input | 4 | Register selector X |
| idx | input | 16 | Index value; the low 12 bits form the base address |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 8 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 8 | Register file write data |
| mem_addr | output | 12 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky protection fault |

## Verification
The bound checker checks the following on every cycle:
- an idle block touches neither memory nor the register file;
- no write enable is ever high with an address below 512;
- reads and writes never overlap, and register writes happen only during a load;
- the fault flag never drops, and `done` never lasts two cycles;
- back-to-back writes step the address by one, with wrap.

Only the bench's scenarios can show the data itself:
- the decimal digits for all 256 source values, and the placement of each register for every X;
- the exact completion cycle of each operation;
- the wrap across address 0 and the abort point of a faulting store;
- that a start pulse arriving mid-operation changes nothing in memory.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [1:0] {
        OP_DIGITS = 2'b00,
        OP_STORE  = 2'b01,
        OP_LOAD   = 2'b10,
        OP_NONE   = 2'b11
    } bxs_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIGITS,
        S_STORE,
        S_LOAD,
        S_LOAD_TAIL,
        S_FINISH
    } bxs_state_e;

endpackage

// File: rtl/bxs_dabble.sv
// Binary to packed decimal conversion by shift-and-add-3.
module bxs_dabble #(
    parameter int BIN_W = 8,
    parameter int DIG   = 3
) (
    input  logic [BIN_W-1:0] bin,
    output logic [4*DIG-1:0] dec
);
    always_comb begin
        logic [4*DIG-1:0] acc;
        acc = '0;
        for (int b = BIN_W - 1; b >= 0; b--) begin
            for (int d = 0; d < DIG; d++) begin
                if (acc[4*d +: 4] >= 4'd5)
                    acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
            end
            acc = {acc[4*DIG-2:0], bin[b]};
        end
        dec = acc;
    end
endmodule

// File: rtl/bxs_guard.sv
// Write-protection compare: writes are allowed only at or above LIMIT.
module bxs_guard #(
    parameter int ADDR_W = 12,
    parameter int LIMIT  = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              allowed
);
    generate
        if (LIMIT <= 0) begin : g_open
            assign allowed = 1'b1;
        end else begin : g_cmp
            assign allowed = (addr >= ADDR_W'(LIMIT));
        end
    endgenerate
endmodule

// File: rtl/bcd_xfer_seq.sv
module bcd_xfer_seq
    import bxs_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 16,
    parameter int SEL_W      = 4,
    parameter int PROT_LIMIT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [SEL_W-1:0]  xsel,
    input  logic [IDX_W-1:0]  idx,
    output logic [SEL_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [SEL_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    localparam int DIG   = (DATA_W * 3 + 9) / 10;
    localparam int DEC_W = 4 * DIG;

    bxs_state_e        state_q, state_d;
    logic [SEL_W-1:0]  cnt_q;
    logic [SEL_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic [DEC_W-1:0]  digits_q;
    logic              ld_pend_q;
    logic [SEL_W-1:0]  ld_reg_q;
    logic              fault_q;

    logic [DEC_W-1:0]  digits_w;
    logic [ADDR_W-1:0] addr_w;
    logic              wr_allowed;
    logic              wr_want;
    logic              wr_block;
    logic [3:0]        dig_sel;
    logic              unused_idx_hi;

    assign unused_idx_hi = ^idx[IDX_W-1:ADDR_W];

    bxs_dabble #(.BIN_W(DATA_W), .DIG(DIG)) u_dabble (
        .bin (rf_rdata),
        .dec (digits_w)
    );

    assign addr_w = base_q + ADDR_W'(cnt_q);

    bxs_guard #(.ADDR_W(ADDR_W), .LIMIT(PROT_LIMIT)) u_guard (
        .addr    (addr_w),
        .allowed (wr_allowed)
    );

    assign wr_want  = (state_q == S_DIGITS) || (state_q == S_STORE);
    assign wr_block = wr_want && !wr_allowed;

    // Digit for the current step: most significant first.
    always_comb begin
        dig_sel = '0;
        for (int d = 0; d < DIG; d++) begin
            if (cnt_q == SEL_W'(DIG - 1 - d))
                dig_sel = digits_q[4*d +: 4];
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    unique case (bxs_op_e'(op))
                        OP_DIGITS: state_d = S_DIGITS;
                        OP_STORE:  state_d = S_STORE;
                        OP_LOAD:   state_d = S_LOAD;
                        OP_NONE:   state_d = S_IDLE;
                    endcase
                end
            end
            S_DIGITS: begin
                if (wr_block)                          state_d = S_IDLE;
                else if (cnt_q == SEL_W'(DIG - 1))     state_d = S_FINISH;
            end
            S_STORE: begin
                if (wr_block)                          state_d = S_IDLE;
                else if (cnt_q == last_q)              state_d = S_FINISH;
            end
            S_LOAD: begin
                if (cnt_q == last_q)                   state_d = S_LOAD_TAIL;
            end
            S_LOAD_TAIL:                               state_d = S_FINISH;
            S_FINISH:                                  state_d = S_IDLE;
            default:                                   state_d = S_IDLE;
        endcase
    end

    // State register and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            last_q    <= '0;
            base_q    <= '0;
            digits_q  <= '0;
            ld_pend_q <= 1'b0;
            ld_reg_q  <= '0;
            fault_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= (state_d != state_q || state_q == S_IDLE) ? '0 : cnt_q + 1'b1;
            ld_pend_q <= (state_q == S_LOAD);
            ld_reg_q  <= cnt_q;
            fault_q   <= fault_q | wr_block;
            if (state_q == S_IDLE && start) begin
                last_q   <= xsel;
                base_q   <= idx[ADDR_W-1:0];
                digits_q <= digits_w;
            end
        end
    end

    // Outputs
    always_comb begin
        rf_raddr  = (state_q == S_STORE) ? cnt_q : xsel;
        mem_addr  = addr_w;
        mem_we    = wr_want && wr_allowed;
        mem_re    = (state_q == S_LOAD);
        mem_wdata = (state_q == S_STORE) ? rf_rdata : DATA_W'(dig_sel);
        rf_we     = ld_pend_q;
        rf_waddr  = ld_reg_q;
        rf_wdata  = mem_rdata;
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        fault     = fault_q;
    end
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
    parameter int ADDR_W     = 12,
    parameter int PROT_LIMIT = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !rf_we));

    assert_no_dual_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_rf_write_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy && !mem_we));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_no_low_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= ADDR_W'(PROT_LIMIT)));

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    assert_fault_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bcd_xfer_seq bxs_checker #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_chk (.*);

// File: tb/bcd_xfer_seq_test.sv
module bcd_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [3:0]  xsel = '0;
    logic [15:0] idx = '0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [7:0]  rf_rdata, rf_wdata, mem_wdata, mem_rdata;
    logic        rf_we, mem_we, mem_re, busy, done, fault;
    logic [11:0] mem_addr;

    logic [7:0] mem [0:4095];
    logic [7:0] rf  [0:15];

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    bcd_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .xsel(xsel), .idx(idx),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Starts an operation and counts cycles until done (or abort).
    task automatic run(input logic [1:0] o, input logic [3:0] x, input logic [15:0] i,
                       input bit disturb, output int cyc, output bit saw_done);
        @(negedge clk);
        op = o; xsel = x; idx = i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        saw_done = 0;
        forever begin
            if (done) begin saw_done = 1; break; end
            if (!busy || cyc > 100) break;
            if (disturb && cyc == 2) begin
                op = 2'b00; xsel = 4'd9; idx = 16'h0300; start = 1'b1;
            end else begin
                start = 1'b0;
                idx = 16'hABCD;
                xsel = 4'hF;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int cyc;
        bit sd;
        do_reset();
        // R1 reset state
        check(!busy && !done && !fault, "R1 reset flags", {busy, done, fault}, 0);
        check(!mem_we && !mem_re && !rf_we, "R1 reset strobes", {mem_we, mem_re, rf_we}, 0);

        // R2 digit store sweep, R8 timing
        for (int v = 0; v < 256; v++) begin
            rf[5] <= 8'(v);
            run(2'b00, 4'd5, 16'h0A00, 0, cyc, sd);
            check(mem[12'hA00] == 8'(v / 100), "R2 hundreds", mem[12'hA00], v / 100);
            check(mem[12'hA01] == 8'((v / 10) % 10), "R2 tens", mem[12'hA01], (v / 10) % 10);
            check(mem[12'hA02] == 8'(v % 10), "R2 ones", mem[12'hA02], v % 10);
            check(sd && cyc == 4, "R8 digit timing", cyc, 4);
        end

        // R3 block store sweep
        for (int x = 0; x < 16; x++) begin
            int b;
            b = 12'h400 + x * 32;
            for (int n = 0; n < 16; n++) rf[n] <= 8'(n * 37 + x * 5 + 1);
            mem[b + x + 1] <= 8'hEE;
            run(2'b01, 4'(x), 16'(b), 0, cyc, sd);
            for (int n = 0; n <= x; n++)
                check(mem[b + n] == 8'(n * 37 + x * 5 + 1), "R3 store byte", mem[b + n], 8'(n * 37 + x * 5 + 1));
            check(mem[b + x + 1] == 8'hEE, "R3 beyond X untouched", mem[b + x + 1], 8'hEE);
            check(sd && cyc == x + 2, "R8 store timing", cyc, x + 2);
        end

        // R4 block load sweep
        for (int x = 0; x < 16; x++) begin
            int b;
            b = 12'h800 + x * 32;
            for (int n = 0; n < 16; n++) begin
                rf[n] <= 8'h5A;
                mem[b + n] <= 8'(n * 29 + x);
            end
            run(2'b10, 4'(x), 16'(b), 0, cyc, sd);
            for (int n = 0; n < 16; n++) begin
                if (n <= x) check(rf[n] == 8'(n * 29 + x), "R4 load reg", rf[n], 8'(n * 29 + x));
                else        check(rf[n] == 8'h5A, "R4 reg above X kept", rf[n], 8'h5A);
            end
            check(sd && cyc == x + 3, "R8 load timing", cyc, x + 3);
        end

        // R5 wrap with upper index bits set
        mem[12'hFFE] <= 8'hA1; mem[12'hFFF] <= 8'hA2; mem[0] <= 8'hA3; mem[1] <= 8'hA4;
        run(2'b10, 4'd3, 16'hFFFE, 0, cyc, sd);
        check(rf[0] == 8'hA1 && rf[1] == 8'hA2, "R5 wrap low", {rf[0], rf[1]}, 16'hA1A2);
        check(rf[2] == 8'hA3 && rf[3] == 8'hA4, "R5 wrap high", {rf[2], rf[3]}, 16'hA3A4);

        // R6 boundary: address 512 is writable
        rf[0] <= 8'h3C;
        run(2'b01, 4'd0, 16'h0200, 0, cyc, sd);
        check(mem[12'h200] == 8'h3C && !fault, "R6 boundary write", mem[12'h200], 8'h3C);

        // R9 start while busy and reserved code ignored
        mem[12'h300] <= 8'h77;
        for (int n = 0; n < 3; n++) rf[n] <= 8'(8'hC0 + n);
        run(2'b01, 4'd2, 16'h0600, 1, cyc, sd);
        check(mem[12'h602] == 8'hC2 && sd && cyc == 4, "R9 capture at start", mem[12'h602], 8'hC2);
        @(negedge clk);
        check(mem[12'h300] == 8'h77, "R9 mid-run start ignored", mem[12'h300], 8'h77);
        op = 2'b11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R9 reserved code", busy, 0);

        // R7 fault mid-store across wrap
        mem[0] <= 8'h11; mem[1] <= 8'h22;
        rf[0] <= 8'h99; rf[1] <= 8'h98; rf[2] <= 8'h97;
        run(2'b01, 4'd2, 16'h0FFF, 0, cyc, sd);
        check(mem[12'hFFF] == 8'h99, "R7 write before fault", mem[12'hFFF], 8'h99);
        check(mem[0] == 8'h11 && mem[1] == 8'h22, "R6 low write suppressed", {mem[0], mem[1]}, 16'h1122);
        check(fault && !sd, "R7 abort without done", {fault, sd}, 2'b10);
        rf[4] <= 8'd137;
        run(2'b00, 4'd4, 16'h0900, 0, cyc, sd);
        check(mem[12'h900] == 1 && mem[12'h901] == 3 && mem[12'h902] == 7 && fault,
              "R7 later op runs, fault sticky", {mem[12'h900], mem[12'h901], mem[12'h902]}, 24'h010307);
        mem[12'h1FF] <= 8'h44;
        run(2'b00, 4'd4, 16'h01FF, 0, cyc, sd);
        check(mem[12'h1FF] == 8'h44 && !sd, "R6 digit store refused", mem[12'h1FF], 8'h44);
        do_reset();
        check(!fault, "R7 fault cleared by reset", fault, 0);

        finish_run();
    end
endmodule